// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the control path of a small 8-bit processor core and owns the steps that move the core into an interrupt handler and back out again. It watches a level-sensitive maskable request and an active-low non-maskable line. It also watches a strobe from the core that marks the end of each instruction. When a request may be taken at such a strobe, the block takes over a byte-wide memory port. It saves the return address and the status byte on a descending stack, sets the interrupt mask, fetches a two-byte handler address and hands it to the core as a program-counter load.

The block also runs the return path. When the core reports that the finishing instruction is a return-from-interrupt, the block pops the status byte and then the two address bytes. It restores the mask from the popped status and delivers both the status and the address to the core. The block holds the stack pointer and the interrupt mask bit. A `busy` output tells the core to stay off the memory port and not fetch until the program-counter load has been issued.

Top module: `irq_entry_seq`

## Requirements
- R1: A pending request starts no sequence until `instr_done` is high while the block is idle; `busy` stays low until the cycle after that boundary.
- R2: On entry, three bytes are written to page $01 at the current stack pointer, each write followed by a decrement of the pointer: return address high byte first, then low byte, then the status byte. The pointer ends 3 below its start.
- R3: The pushed status byte equals `flags_in` with bit 2 replaced by the mask value at the boundary. The mask (`irq_mask`, status bit 2) becomes 1 in the cycle after the status byte is written.
- R4: The maskable handler address is read little-endian from $FFFE (low) and $FFFF (high). The non-maskable one is read from $FFFA and $FFFB. `pc_load` pulses once with `pc_new` equal to that address, and `flags_load` stays low on entry.
- R5: `irq_lvl` is ignored while `irq_mask` is 1. A non-maskable request is taken whatever the mask.
- R6: A falling edge of `nmi_n` is remembered until it is serviced and gives exactly one entry; holding `nmi_n` low gives no further entry.
- R7: When both kinds are pending at one boundary, the non-maskable one is taken first. A maskable request still pending is taken at a later boundary once the mask is clear.
- R8: A boundary with `rti_op` high reads page $01 at pointer+1 three times, incrementing the pointer each time: status, then address low, then address high. `irq_mask` takes bit 2 of the popped status. `pc_load` and `flags_load` pulse together with the popped address and status.
- R9: `sei_op` sets and `cli_op` clears `irq_mask` while idle (`sei_op` wins if both are high); both are ignored while `busy` is high.
- R10: An entry keeps `busy` high for exactly 6 cycles and a return for 4; `pc_load` occurs in the last busy cycle; no memory access happens while `busy` is low.
- R11: After reset, `busy` is 0, `irq_mask` is 1, the stack pointer is $FF and no memory access is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_lvl | input | 1 | Maskable request, active high, level sensitive |
| nmi_n | input | 1 | Non-maskable request, active low, falling edge sensitive |
| instr_done | input | 1 | Core strobe: the current instruction has finished all of its cycles |
| rti_op | input | 1 | With `instr_done`: the finishing instruction is a return-from-interrupt |
| sei_op | input | 1 | Set the interrupt mask |
| cli_op | input | 1 | Clear the interrupt mask |
| ret_pc | input | 16 | Address of the next instruction, captured at the boundary |
| flags_in | input | 8 | Core status byte, captured at the boundary |
| mem_addr | output | 16 | Memory port address |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid in the same cycle as the address |
| busy | output | 1 | Sequence in progress; the core must not fetch |
| irq_mask | output | 1 | Interrupt mask (status bit 2) |
| sp | output | 8 | Stack pointer within page $01 |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | 16 | Handler or return address |
| flags_load | output | 1 | Load `flags_new` into the status register |
| flags_new | output | 8 | Popped status byte |

## Verification
The bench runs entries from both sources with the mask set and clear, then returns from each. It checks the order of the stacked bytes and their addresses, because a swapped push or pop order, or a pointer moved before the write instead of after, would still come back to the same pointer value while handing the core a byte-swapped return address. A request raised together with a held non-maskable line probes the edge latch and the priority: a level-sensitive design would re-enter the non-maskable handler forever, and a wrong priority would jump to the maskable vector first. Mask strobes given in the middle of a sequence, and a maskable request raised while the mask is set, show whether the mask can be cleared inside a handler's entry or whether a masked request slips through.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_PUSH_HI,
    S_PUSH_LO,
    S_PUSH_FL,
    S_VEC_LO,
    S_VEC_HI,
    S_POP_FL,
    S_POP_LO,
    S_POP_HI,
    S_LOAD
  } seq_state_t;

  function automatic logic is_push(input seq_state_t s);
    return (s == S_PUSH_HI) || (s == S_PUSH_LO) || (s == S_PUSH_FL);
  endfunction

  function automatic logic is_pop(input seq_state_t s);
    return (s == S_POP_FL) || (s == S_POP_LO) || (s == S_POP_HI);
  endfunction

endpackage

// File: rtl/irq_seq_rst_sync.sv
module irq_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/irq_seq_arbiter.sv
module irq_seq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_lvl,
  input  logic nmi_n,
  input  logic irq_mask,
  input  logic take,
  output logic want,
  output logic pick_nmi
);

  logic nmi_prev_q, nmi_prev_d;
  logic pend_q, pend_d;
  logic nmi_fall;

  always_comb begin
    nmi_fall   = nmi_prev_q & ~nmi_n;
    nmi_prev_d = nmi_n;
    // a new edge wins over a clear in the same cycle
    pend_d     = nmi_fall | (pend_q & ~take);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev_q <= 1'b1;
      pend_q     <= 1'b0;
    end else begin
      nmi_prev_q <= nmi_prev_d;
      pend_q     <= pend_d;
    end
  end

  assign want     = pend_q | (irq_lvl & ~irq_mask);
  assign pick_nmi = pend_q;

endmodule

// File: rtl/irq_seq_mask.sv
module irq_seq_mask (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic sei_op,
  input  logic cli_op,
  input  logic set_entry,
  input  logic restore_en,
  input  logic restore_val,
  output logic irq_mask
);

  logic mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (idle) begin
      if (cli_op) mask_d = 1'b0;
      if (sei_op) mask_d = 1'b1;
    end
    if (set_entry)  mask_d = 1'b1;
    if (restore_en) mask_d = restore_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
    end else begin
      mask_q <= mask_d;
    end
  end

  assign irq_mask = mask_q;

endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
  parameter int              DATA_W  = 8,
  parameter logic [DATA_W-1:0] SP_INIT = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec,
  input  logic              inc,
  output logic [DATA_W-1:0] sp,
  output logic [DATA_W-1:0] sp_up
);

  logic [DATA_W-1:0] sp_q, sp_d;
  logic              sp_en;

  always_comb begin
    sp_up = sp_q + DATA_W'(1);
    sp_en = dec | inc;
    sp_d  = dec ? (sp_q - DATA_W'(1)) : sp_up;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q <= SP_INIT;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp = sp_q;

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_int,
  input  logic       start_ret,
  output seq_state_t state
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (start_ret)      state_d = S_POP_FL;
        else if (start_int) state_d = S_PUSH_HI;
      end
      S_PUSH_HI: state_d = S_PUSH_LO;
      S_PUSH_LO: state_d = S_PUSH_FL;
      S_PUSH_FL: state_d = S_VEC_LO;
      S_VEC_LO:  state_d = S_VEC_HI;
      S_VEC_HI:  state_d = S_LOAD;
      S_POP_FL:  state_d = S_POP_LO;
      S_POP_LO:  state_d = S_POP_HI;
      S_POP_HI:  state_d = S_LOAD;
      S_LOAD:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_seq_pkg::*;
#(
  parameter int                  DATA_W      = 8,
  parameter logic [DATA_W-1:0]   STACK_PAGE  = 8'h01,
  parameter logic [2*DATA_W-1:0] IRQ_VEC     = 16'hFFFE,
  parameter logic [2*DATA_W-1:0] NMI_VEC     = 16'hFFFA,
  parameter logic [DATA_W-1:0]   SP_INIT     = 8'hFF,
  parameter int                  I_BIT       = 2,
  parameter int                  SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  irq_lvl,
  input  logic                  nmi_n,
  input  logic                  instr_done,
  input  logic                  rti_op,
  input  logic                  sei_op,
  input  logic                  cli_op,
  input  logic [2*DATA_W-1:0]   ret_pc,
  input  logic [DATA_W-1:0]     flags_in,
  output logic [2*DATA_W-1:0]   mem_addr,
  output logic                  mem_wr,
  output logic                  mem_rd,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  busy,
  output logic                  irq_mask,
  output logic [DATA_W-1:0]     sp,
  output logic                  pc_load,
  output logic [2*DATA_W-1:0]   pc_new,
  output logic                  flags_load,
  output logic [DATA_W-1:0]     flags_new
);

  localparam int              ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] I_SEL = DATA_W'(1) << I_BIT;

  logic              rst_int_n;
  seq_state_t        state;
  logic              idle;
  logic              boundary;
  logic              start_int;
  logic              start_ret;
  logic              want;
  logic              pick_nmi;
  logic              in_push;
  logic              in_pop;
  logic [DATA_W-1:0] sp_up;
  logic [DATA_W-1:0] fl_push;
  logic              popped_mask;

  logic [ADDR_W-1:0] ret_q;
  logic [DATA_W-1:0] flp_q;
  logic              src_nmi_q;
  logic              ret_mode_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] popfl_q;
  logic              cap_en;
  logic              mode_en;
  logic              lo_en;
  logic              hi_en;
  logic              fl_en;
  logic [ADDR_W-1:0] vec_base;

  irq_seq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    idle      = (state == S_IDLE);
    boundary  = idle & instr_done;
    start_ret = boundary & rti_op;
    start_int = boundary & ~rti_op & want;
    in_push   = is_push(state);
    in_pop    = is_pop(state);
    fl_push   = (flags_in & ~I_SEL) | (irq_mask ? I_SEL : '0);
    popped_mask = |(mem_rdata & I_SEL);
  end

  irq_seq_arbiter u_arb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .irq_lvl  (irq_lvl),
    .nmi_n    (nmi_n),
    .irq_mask (irq_mask),
    .take     (start_int),
    .want     (want),
    .pick_nmi (pick_nmi)
  );

  irq_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_int (start_int),
    .start_ret (start_ret),
    .state     (state)
  );

  irq_seq_stack #(.DATA_W(DATA_W), .SP_INIT(SP_INIT)) u_stk (
    .clk   (clk),
    .rst_n (rst_int_n),
    .dec   (in_push),
    .inc   (in_pop),
    .sp    (sp),
    .sp_up (sp_up)
  );

  irq_seq_mask u_msk (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .idle        (idle),
    .sei_op      (sei_op),
    .cli_op      (cli_op),
    .set_entry   (state == S_PUSH_FL),
    .restore_en  (state == S_POP_FL),
    .restore_val (popped_mask),
    .irq_mask    (irq_mask)
  );

  // capture enables
  always_comb begin
    cap_en  = start_int;
    mode_en = start_int | start_ret;
    lo_en   = (state == S_VEC_LO) | (state == S_POP_LO);
    hi_en   = (state == S_VEC_HI) | (state == S_POP_HI);
    fl_en   = (state == S_POP_FL);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ret_q      <= '0;
      flp_q      <= '0;
      src_nmi_q  <= 1'b0;
      ret_mode_q <= 1'b0;
      lo_q       <= '0;
      hi_q       <= '0;
      popfl_q    <= '0;
    end else begin
      if (cap_en) begin
        ret_q     <= ret_pc;
        flp_q     <= fl_push;
        src_nmi_q <= pick_nmi;
      end
      if (mode_en) ret_mode_q <= start_ret;
      if (lo_en)   lo_q       <= mem_rdata;
      if (hi_en)   hi_q       <= mem_rdata;
      if (fl_en)   popfl_q    <= mem_rdata;
    end
  end

  // memory port
  always_comb begin
    vec_base  = src_nmi_q ? NMI_VEC : IRQ_VEC;
    mem_addr  = '0;
    mem_wr    = 1'b0;
    mem_rd    = 1'b0;
    mem_wdata = '0;
    case (state)
      S_PUSH_HI: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wr    = 1'b1;
        mem_wdata = ret_q[ADDR_W-1:DATA_W];
      end
      S_PUSH_LO: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wr    = 1'b1;
        mem_wdata = ret_q[DATA_W-1:0];
      end
      S_PUSH_FL: begin
        mem_addr  = {STACK_PAGE, sp};
        mem_wr    = 1'b1;
        mem_wdata = flp_q;
      end
      S_VEC_LO: begin
        mem_addr = vec_base;
        mem_rd   = 1'b1;
      end
      S_VEC_HI: begin
        mem_addr = vec_base + ADDR_W'(1);
        mem_rd   = 1'b1;
      end
      S_POP_FL, S_POP_LO, S_POP_HI: begin
        mem_addr = {STACK_PAGE, sp_up};
        mem_rd   = 1'b1;
      end
      default: begin
        mem_addr = '0;
      end
    endcase
  end

  assign busy       = ~idle;
  assign pc_load    = (state == S_LOAD);
  assign pc_new     = {hi_q, lo_q};
  assign flags_load = (state == S_LOAD) & ret_mode_q;
  assign flags_new  = popfl_q;

endmodule

// File: rtl/irq_entry_seq_chk.sv
module irq_entry_seq_chk #(
  parameter int                DATA_W     = 8,
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter int                I_BIT      = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic                instr_done,
  input logic                busy,
  input logic                irq_mask,
  input logic [DATA_W-1:0]   sp,
  input logic [2*DATA_W-1:0] mem_addr,
  input logic                mem_wr,
  input logic                mem_rd,
  input logic [DATA_W-1:0]   mem_rdata,
  input logic                pc_load
);

  localparam int                ADDR_W = 2 * DATA_W;
  localparam logic [DATA_W-1:0] I_SEL  = DATA_W'(1) << I_BIT;

  logic on_stack;
  logic rd_mask_bit;
  assign on_stack    = (mem_addr >> DATA_W) == ADDR_W'(STACK_PAGE);
  assign rd_mask_bit = |(mem_rdata & I_SEL);

  assert_write_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> on_stack);

  assert_push_dec_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> sp == DATA_W'($past(sp) - DATA_W'(1)));

  assert_pop_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && on_stack) |=> sp == DATA_W'($past(sp) + DATA_W'(1)));

  assert_wait_boundary_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(instr_done));

  assert_mask_after_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(irq_mask)) |-> ($past(mem_wr) || ($past(mem_rd) && $past(rd_mask_bit))));

  assert_load_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);

  assert_load_ends_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_wr && !mem_rd));

endmodule

bind irq_entry_seq irq_entry_seq_chk #(
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE),
  .I_BIT      (I_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_done (instr_done),
  .busy       (busy),
  .irq_mask   (irq_mask),
  .sp         (sp),
  .mem_addr   (mem_addr),
  .mem_wr     (mem_wr),
  .mem_rd     (mem_rd),
  .mem_rdata  (mem_rdata),
  .pc_load    (pc_load)
);

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] IRQ_HANDLER = 16'hE1C0;
  localparam logic [15:0] NMI_HANDLER = 16'hF20D;

  typedef struct packed {
    logic        use_nmi;
    logic        mask0;
    logic [15:0] pc;
    logic [7:0]  fl;
  } vec_t;

  localparam vec_t VT [4] = '{
    '{1'b0, 1'b0, 16'h1234, 8'hA1},
    '{1'b1, 1'b0, 16'h8001, 8'h00},
    '{1'b1, 1'b1, 16'hFFFE, 8'hFF},
    '{1'b0, 1'b0, 16'h00FF, 8'h5A}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_lvl = 1'b0;
  logic        nmi_n = 1'b1;
  logic        instr_done = 1'b0;
  logic        rti_op = 1'b0;
  logic        sei_op = 1'b0;
  logic        cli_op = 1'b0;
  logic [15:0] ret_pc = 16'h0000;
  logic [7:0]  flags_in = 8'h00;
  logic [15:0] mem_addr;
  logic        mem_wr;
  logic        mem_rd;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;
  logic        busy;
  logic        irq_mask;
  logic [7:0]  sp;
  logic        pc_load;
  logic [15:0] pc_new;
  logic        flags_load;
  logic [7:0]  flags_new;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0]  stk [256];
  logic [15:0] wl_addr [16];
  logic [7:0]  wl_data [16];
  int          wr_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_entry_seq i_irq_entry_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lvl    (irq_lvl),
    .nmi_n      (nmi_n),
    .instr_done (instr_done),
    .rti_op     (rti_op),
    .sei_op     (sei_op),
    .cli_op     (cli_op),
    .ret_pc     (ret_pc),
    .flags_in   (flags_in),
    .mem_addr   (mem_addr),
    .mem_wr     (mem_wr),
    .mem_rd     (mem_rd),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .busy       (busy),
    .irq_mask   (irq_mask),
    .sp         (sp),
    .pc_load    (pc_load),
    .pc_new     (pc_new),
    .flags_load (flags_load),
    .flags_new  (flags_new)
  );

  // behavioural memory: stack page plus the four vector bytes
  always_comb begin
    if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else begin
      case (mem_addr)
        16'hFFFA: mem_rdata = NMI_HANDLER[7:0];
        16'hFFFB: mem_rdata = NMI_HANDLER[15:8];
        16'hFFFE: mem_rdata = IRQ_HANDLER[7:0];
        16'hFFFF: mem_rdata = IRQ_HANDLER[15:8];
        default:  mem_rdata = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (mem_wr) begin
      stk[mem_addr[7:0]]  <= mem_wdata;
      wl_addr[wr_cnt % 16] <= mem_addr;
      wl_data[wr_cnt % 16] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one instruction boundary, then follow any sequence to its end
  task automatic run_boundary(input logic ret, output int bcnt, output logic [15:0] pcv,
                              output logic [7:0] fv, output logic fl, output int loads);
    @(negedge clk);
    instr_done = 1'b1;
    rti_op     = ret;
    @(negedge clk);
    instr_done = 1'b0;
    rti_op     = 1'b0;
    bcnt = 0; pcv = 16'h0; fv = 8'h0; fl = 1'b0; loads = 0;
    for (int k = 0; k < 20; k++) begin
      if (!busy) break;
      bcnt++;
      if (pc_load) begin
        pcv = pc_new; fv = flags_new; fl = flags_load; loads++;
      end
      @(negedge clk);
    end
  endtask

  task automatic pulse_mask(input logic set);
    @(negedge clk);
    sei_op = set;
    cli_op = ~set;
    @(negedge clk);
    sei_op = 1'b0;
    cli_op = 1'b0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int          bcnt;
    logic [15:0] pcv;
    logic [7:0]  fv;
    logic        fl;
    int          loads;
    logic [7:0]  sp0;
    logic [7:0]  pushed;
    int          base;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11", "busy after reset", busy, 0);
    chk("R11", "mask after reset", irq_mask, 1);
    chk("R11", "sp after reset", sp, 8'hFF);
    chk("R11", "no write after reset", mem_wr | mem_rd, 0);

    // table of entry/return cases
    for (int v = 0; v < 4; v++) begin
      pulse_mask(VT[v].mask0);
      ret_pc   = VT[v].pc;
      flags_in = VT[v].fl;
      sp0      = sp;
      pushed   = (VT[v].fl & 8'hFB) | (VT[v].mask0 ? 8'h04 : 8'h00);
      if (VT[v].use_nmi) nmi_n = 1'b0;
      else irq_lvl = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", "busy before boundary", busy, 0);
      base = wr_cnt;
      run_boundary(1'b0, bcnt, pcv, fv, fl, loads);
      irq_lvl = 1'b0;
      nmi_n   = 1'b1;
      chk("R10", "entry busy cycles", bcnt, 6);
      chk("R4", "single pc load", loads, 1);
      chk("R4", "handler address", pcv, VT[v].use_nmi ? NMI_HANDLER : IRQ_HANDLER);
      chk("R4", "no flags load on entry", fl, 0);
      chk("R2", "write count", wr_cnt - base, 3);
      chk("R2", "push1 addr", wl_addr[base % 16], {8'h01, sp0});
      chk("R2", "push1 data", wl_data[base % 16], VT[v].pc[15:8]);
      chk("R2", "push2 addr", wl_addr[(base + 1) % 16], {8'h01, 8'(sp0 - 8'd1)});
      chk("R2", "push2 data", wl_data[(base + 1) % 16], VT[v].pc[7:0]);
      chk("R2", "push3 addr", wl_addr[(base + 2) % 16], {8'h01, 8'(sp0 - 8'd2)});
      chk("R3", "pushed flags", wl_data[(base + 2) % 16], pushed);
      chk("R2", "sp after entry", sp, 8'(sp0 - 8'd3));
      chk("R3", "mask set in handler", irq_mask, 1);

      run_boundary(1'b1, bcnt, pcv, fv, fl, loads);
      chk("R10", "return busy cycles", bcnt, 4);
      chk("R8", "return address", pcv, VT[v].pc);
      chk("R8", "flags load on return", fl, 1);
      chk("R8", "popped flags", fv, pushed);
      chk("R8", "mask restored", irq_mask, VT[v].mask0);
      chk("R8", "sp after return", sp, sp0);
    end

    // R5: masked request ignored
    pulse_mask(1'b1);
    irq_lvl = 1'b1;
    run_boundary(1'b0, bcnt, pcv, fv, fl, loads);
    chk("R5", "masked irq not taken", bcnt, 0);
    chk("R5", "no write while masked", wr_cnt - base, 3);

    // R7/R6: both pending, non-maskable first, held low gives one entry
    pulse_mask(1'b0);
    nmi_n = 1'b0;
    repeat (2) @(negedge clk);
    run_boundary(1'b0, bcnt, pcv, fv, fl, loads);
    chk("R7", "nmi wins", pcv, NMI_HANDLER);
    run_boundary(1'b1, bcnt, pcv, fv, fl, loads);
    chk("R7", "mask clear after return", irq_mask, 0);
    run_boundary(1'b0, bcnt, pcv, fv, fl, loads);
    irq_lvl = 1'b0;
    chk("R6", "held nmi does not re-enter, irq taken", pcv, IRQ_HANDLER);
    run_boundary(1'b1, bcnt, pcv, fv, fl, loads);
    run_boundary(1'b0, bcnt, pcv, fv, fl, loads);
    chk("R6", "no entry on held low nmi", bcnt, 0);
    nmi_n = 1'b1;

    // R9: mask strobes
    pulse_mask(1'b1);
    chk("R9", "sei sets mask", irq_mask, 1);
    pulse_mask(1'b0);
    chk("R9", "cli clears mask", irq_mask, 0);
    @(negedge clk);
    sei_op = 1'b1; cli_op = 1'b1;
    @(negedge clk);
    sei_op = 1'b0; cli_op = 1'b0;
    chk("R9", "sei wins over cli", irq_mask, 1);
    pulse_mask(1'b0);
    irq_lvl = 1'b1;
    @(negedge clk);
    instr_done = 1'b1;
    @(negedge clk);
    instr_done = 1'b0;
    irq_lvl = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (irq_mask) break;
      @(negedge clk);
    end
    chk("R9", "busy while mask set", busy, 1);
    cli_op = 1'b1;
    @(negedge clk);
    cli_op = 1'b0;
    for (int k = 0; k < 10; k++) begin
      if (!busy) break;
      @(negedge clk);
    end
    chk("R9", "cli ignored while busy", irq_mask, 1);
    run_boundary(1'b1, bcnt, pcv, fv, fl, loads);
    chk("R8", "sp back to top", sp, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule